// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational 16-bit binary adder. It takes two operands and a carry input and returns the sum and the carry output. The operand width is split into four slices of four bits. Each slice forms per-bit generate (`a & b`) and propagate (`a | b`) terms and uses them to find its own internal carries directly, with no rippling. Each slice also reports a slice-level propagate and a slice-level generate.

A second lookahead unit takes the four slice-level propagate and generate terms, together with the carry input. From these it finds the carry into every slice and the final carry output, again as flat sum-of-products logic with no carry chain between slices. The slice-level propagate and generate terms are brought out as ports, so that a wider adder can place a third lookahead level above this one.

The slice width and the slice count are parameters. The default is four slices of four bits.

Top module: `cla2_adder`

## Requirements
- R1: `sum_o` equals `(a_i + b_i + cin_i) mod 2^16`, for every operand pair and for both carry-in values.
- R2: `cout_o` equals bit 16 of the 17-bit sum `a_i + b_i + cin_i`.
- R3: `grp_g_o[k]` is 1 exactly when the 4-bit slice `a_i[4k+3:4k] + b_i[4k+3:4k]`, taken with zero carry-in, exceeds 15. The bits are ordered slice 0 at the least significant end.
- R4: `grp_p_o[k]` is 1 exactly when every bit position in slice k has at least one operand bit set, that is when `(a_i | b_i)` over bits `[4k+3:4k]` is 4'hF.
- R5: The carry into slice k+1 equals `grp_g_o[k] | (grp_p_o[k] & c_k)`, where c_k is the carry into slice k, c_0 is `cin_i`, and the carry into slice 4 is `cout_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum modulo 2^16 |
| cout_o | output | 1 | Carry out of bit 15 |
| grp_p_o | output | 4 | Slice-level propagate, one bit per slice |
| grp_g_o | output | 4 | Slice-level generate, one bit per slice |

## Verification
The bench builds two copies of the block.

- The first uses the default parameters (16 bits, four slices of four).
- The second uses two slices of two bits. At four bits wide, every operand pair and both carry-in values can be applied, 512 vectors in all. This exercises every carry pattern through both lookahead levels, including the case where a carry created in the lowest bit crosses every slice.

The 16-bit copy is driven with corner operands crossed with each other (zero, all ones, single-bit values, alternating patterns, and values that make single slices propagate or generate) and with a fixed-seed random sweep. For each vector, every output and the slice-carry recurrence are compared with values worked out arithmetically in the bench.

// File: rtl/cla2_pkg.sv
package cla2_pkg;
  localparam int unsigned GROUP_W_DEF  = 4;
  localparam int unsigned N_GROUPS_DEF = 4;
endpackage

// File: rtl/cla_unit.sv
// Flat lookahead: carries into each position as sums of products, no chain.
module cla_unit #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] g_i,
  input  logic         cin_i,
  output logic [N-1:0] c_o,
  output logic         cout_o,
  output logic         grp_p_o,
  output logic         grp_g_o
);
  logic [N:0] carry;

  always_comb begin
    logic acc;
    logic term;
    carry    = '0;
    carry[0] = cin_i;
    for (int k = 1; k <= N; k++) begin
      acc = 1'b0;
      for (int j = 0; j <= k; j++) begin
        term = (j == 0) ? cin_i : g_i[j-1];
        for (int m = j; m < k; m++) term = term & p_i[m];
        acc = acc | term;
      end
      carry[k] = acc;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 1; j <= N; j++) begin
      term = g_i[j-1];
      for (int m = j; m < N; m++) term = term & p_i[m];
      acc = acc | term;
    end
    grp_g_o = acc;
  end

  assign grp_p_o = &p_i;
  assign c_o     = carry[N-1:0];
  assign cout_o  = carry[N];

  always_comb begin
    for (int k = 0; k < N; k++) begin
      p_carry_step_r5: assert (carry[k+1] == (g_i[k] | (p_i[k] & carry[k])))
        else $error("carry step mismatch at %0d", k);
    end
    p_group_carry_r5: assert (cout_o == (grp_g_o | (grp_p_o & cin_i)))
      else $error("group carry mismatch");
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         grp_p_o,
  output logic         grp_g_o
);
  logic [W-1:0] bit_g, bit_p, bit_c;
  logic         slice_cout;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i | b_i;

  cla_unit #(.N(W)) u_bit_la (
    .p_i    (bit_p),
    .g_i    (bit_g),
    .cin_i  (cin_i),
    .c_o    (bit_c),
    .cout_o (slice_cout),
    .grp_p_o(grp_p_o),
    .grp_g_o(grp_g_o)
  );

  assign sum_o = a_i ^ b_i ^ bit_c;

  always_comb begin
    logic [W:0] raw;
    logic [W:0] full;
    raw  = {1'b0, a_i} + {1'b0, b_i};
    full = raw + {{W{1'b0}}, cin_i};
    p_slice_gen_r3: assert (grp_g_o == raw[W]) else $error("slice generate mismatch");
    p_slice_prop_r4: assert (grp_p_o == (&(a_i | b_i))) else $error("slice propagate mismatch");
    p_slice_sum_r1: assert ({slice_cout, sum_o} == full) else $error("slice sum mismatch");
  end
endmodule

// File: rtl/cla2_adder.sv
module cla2_adder #(
  parameter int unsigned GROUP_W  = cla2_pkg::GROUP_W_DEF,
  parameter int unsigned N_GROUPS = cla2_pkg::N_GROUPS_DEF,
  localparam int unsigned WIDTH   = GROUP_W * N_GROUPS
) (
  input  logic [WIDTH-1:0]    a_i,
  input  logic [WIDTH-1:0]    b_i,
  input  logic                cin_i,
  output logic [WIDTH-1:0]    sum_o,
  output logic                cout_o,
  output logic [N_GROUPS-1:0] grp_p_o,
  output logic [N_GROUPS-1:0] grp_g_o
);
  logic [N_GROUPS-1:0] grp_c;
  logic                top_p, top_g;

  for (genvar k = 0; k < N_GROUPS; k++) begin : g_slice
    cla_group #(.W(GROUP_W)) u_group (
      .a_i    (a_i[k*GROUP_W +: GROUP_W]),
      .b_i    (b_i[k*GROUP_W +: GROUP_W]),
      .cin_i  (grp_c[k]),
      .sum_o  (sum_o[k*GROUP_W +: GROUP_W]),
      .grp_p_o(grp_p_o[k]),
      .grp_g_o(grp_g_o[k])
    );
  end

  // second level: slice carries from slice P/G, no inter-slice ripple
  cla_unit #(.N(N_GROUPS)) u_grp_la (
    .p_i    (grp_p_o),
    .g_i    (grp_g_o),
    .cin_i  (cin_i),
    .c_o    (grp_c),
    .cout_o (cout_o),
    .grp_p_o(top_p),
    .grp_g_o(top_g)
  );

  always_comb begin
    logic [WIDTH:0] full;
    full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    p_sum_r1: assert (sum_o == full[WIDTH-1:0]) else $error("sum mismatch");
    p_cout_r2: assert (cout_o == full[WIDTH]) else $error("carry out mismatch");
    p_top_carry_r5: assert (cout_o == (top_g | (top_p & cin_i))) else $error("top carry mismatch");
  end
endmodule

// File: tb/cla2_adder_bench.sv
`timescale 1ns/1ps
module cla2_adder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        ci16 = 1'b0, co16;
  logic [3:0]  p16, g16;
  logic [3:0]  a4 = '0, b4 = '0, s4;
  logic        ci4 = 1'b0, co4;
  logic [1:0]  p4, g4;

  cla2_adder u_cla2_adder (
    .a_i(a16), .b_i(b16), .cin_i(ci16), .sum_o(s16), .cout_o(co16),
    .grp_p_o(p16), .grp_g_o(g16)
  );

  cla2_adder #(.GROUP_W(2), .N_GROUPS(2)) u_cla2_adder_small (
    .a_i(a4), .b_i(b4), .cin_i(ci4), .sum_o(s4), .cout_o(co4),
    .grp_p_o(p4), .grp_g_o(g4)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic verify(input int w, input int gw, input longint a, input longint b,
                        input longint cin, input longint s, input longint co,
                        input longint gp, input longint gg);
    longint mask, gm, tot, ga, gb, ep, eg, lm, ck, cn;
    int ng;
    ng   = w / gw;
    mask = (64'd1 << w) - 1;
    gm   = (64'd1 << gw) - 1;
    tot  = a + b + cin;
    chk(s == (tot & mask), "R1 sum", s, tot & mask);
    chk(co == (tot >> w), "R2 cout", co, tot >> w);
    ck = cin;
    for (int k = 0; k < ng; k++) begin
      ga = (a >> (k*gw)) & gm;
      gb = (b >> (k*gw)) & gm;
      eg = ((ga + gb) >> gw) & 1;
      ep = ((ga | gb) == gm) ? 1 : 0;
      chk(((gg >> k) & 1) == eg, "R3 group generate", (gg >> k) & 1, eg);
      chk(((gp >> k) & 1) == ep, "R4 group propagate", (gp >> k) & 1, ep);
      lm = (64'd1 << ((k+1)*gw)) - 1;
      cn = ((a & lm) + (b & lm) + cin) >> ((k+1)*gw);
      chk((((gg >> k) & 1) | (((gp >> k) & 1) & ck)) == cn, "R5 slice carry",
          ((gg >> k) & 1) | (((gp >> k) & 1) & ck), cn);
      ck = cn;
    end
  endtask

  task automatic apply16(input logic [15:0] a, input logic [15:0] b, input logic c);
    @(negedge clk);
    a16 = a; b16 = b; ci16 = c;
    #1;
    verify(16, 4, a, b, c, s16, co16, p16, g16);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] corners [12];
    corners = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000, 16'hAAAA, 16'h5555,
                16'h000F, 16'h00F0, 16'h0F00, 16'hF000, 16'h7FFF, 16'h1234};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // zero operands after start: all outputs clear (R1, R2)
    #1;
    chk(s16 == 16'h0 && co16 == 1'b0, "R1 idle sum zero", s16, 0);
    chk(p16 == 4'h0 && g16 == 4'h0, "R4 idle group terms zero", {p16, g16}, 0);
    // R5 carry crossing every slice: a = ~b, cin = 1
    apply16(16'h5A5A, 16'hA5A5, 1'b1);
    chk(s16 == 16'h0 && co16 == 1'b1, "R5 full propagate chain", {co16, s16}, 17'h10000);
    // exhaustive small configuration
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          a4 = a[3:0]; b4 = b[3:0]; ci4 = c[0];
          #1;
          verify(4, 2, a, b, c, s4, co4, p4, g4);
        end
    // corner cross product at default width
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int c = 0; c < 2; c++)
          apply16(corners[i], corners[j], c[0]);
    // random sweep
    begin
      int unsigned seed;
      seed = 32'd17;
      void'($urandom(seed));
      for (int n = 0; n < 3000; n++) begin
        logic [31:0] r;
        r = $urandom;
        apply16(r[15:0], r[31:16], n[0]);
      end
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule